// File: doc/BRIEF.md
# Q1.23 Multiply-Accumulate Unit

This unit multiplies two signed 24-bit fractional operands (Q1.23: one sign bit and 23 fraction bits) at full precision and either loads the product into a wide accumulator or adds it to the running sum. A 2-bit operation code chosen per cycle picks one of three actions: keep the accumulator, replace it with the new product, or add the new product to it. The unit is meant to sit inside a filter datapath. A coefficient times a sample starts a new sum, and further products are then summed into it.

The 24-bit result is a fixed window of the accumulator, bits 2*DW-2 down to DW-1 (46 down to 23 by default). This window drops the redundant second sign bit of a fractional product, so the result reads as another Q1.23 value. The accumulator has no saturation. It wraps modulo 2^ACC_W. The result and a valid flag come out of a two-stage pipeline: the operands are registered, and then the accumulator and the output slice are updated.

Top module: `q23_mac`

## Requirements
- R1: Operands `a_i` and `b_i` are signed two's-complement DW-bit values, and their product is formed exactly at 2*DW bits for every sign combination.
- R2: `res_o` equals bits 2*DW-2 down to DW-1 of the accumulator value written by the latest load or accumulate operation.
- R3: Operation code 2'b01 (load) sets the accumulator to the sign-extended new product. Earlier contents do not contribute.
- R4: Operation code 2'b10 (accumulate) adds the sign-extended new product to the current accumulator contents.
- R5: Operation codes 2'b00 and 2'b11 (hold) leave the accumulator and `res_o` unchanged and keep `vld_o` low.
- R6: The accumulator is ACC_W bits wide (at least 2*DW) and wraps modulo 2^ACC_W on overflow, with no saturation.
- R7: When the product has no set bits at or above bit DW-1, a load gives `res_o` equal to zero.
- R8: An operation sampled at rising edge k drives its result and `vld_o` after rising edge k+1. `vld_o` is high for exactly that one cycle and only for load or accumulate. Operations may be issued on back-to-back cycles.
- R9: Synchronous active-high `rst_i` clears the accumulator, `res_o` and `vld_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | 00/11 hold, 01 load, 10 accumulate |
| a_i | input | DW | Operand A, signed Q1.(DW-1) |
| b_i | input | DW | Operand B, signed Q1.(DW-1) |
| res_o | output | DW | Accumulator slice [2*DW-2:DW-1] |
| vld_o | output | 1 | High one cycle when res_o is updated |

## Verification
A six-bit configuration runs a load on every one of the 4096 operand pairs. This covers all sign combinations, the most negative value squared, and the products that fall entirely below the output window, which separates a correct slice position and sign extension from an off-by-one slice. A separate accumulate chain on that small configuration and on the full-width unit drives the sum past the accumulator range, which shows wrapping rather than clamping. Back-to-back load/accumulate pairs, idle hold cycles with both hold encodings, and a reset in the middle of a sum check the pipeline timing, that the valid flag fires only on load and accumulate, and that reset clears the accumulator.

// File: rtl/q23_mac_pkg.sv
package q23_mac_pkg;

    // Operation encoding on op_i
    typedef enum logic [1:0] {
        MAC_HOLD  = 2'b00,
        MAC_LOAD  = 2'b01,
        MAC_ACC   = 2'b10,
        MAC_HOLD2 = 2'b11
    } mac_op_e;

    function automatic logic op_updates(input logic [1:0] op);
        return (op == MAC_LOAD) || (op == MAC_ACC);
    endfunction

endpackage

// File: rtl/q23_mult.sv
module q23_mult #(
    parameter int DW = 24
) (
    input  logic [DW-1:0]          a_i,
    input  logic [DW-1:0]          b_i,
    output logic signed [2*DW-1:0] prod_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    // Sign-extend both operands to full product width before multiplying
    assign a_ext  = PW'($signed(a_i));
    assign b_ext  = PW'($signed(b_i));
    assign prod_o = a_ext * b_ext;

endmodule

// File: rtl/q23_acc_update.sv
module q23_acc_update
    import q23_mac_pkg::*;
#(
    parameter int PW    = 48,
    parameter int ACC_W = 48
) (
    input  logic [1:0]              op_i,
    input  logic signed [PW-1:0]    prod_i,
    input  logic signed [ACC_W-1:0] acc_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic                    upd_o
);
    localparam int EXT = ACC_W - PW;

    logic signed [ACC_W-1:0] prod_ext;

    generate
        if (EXT > 0) begin : g_ext
            assign prod_ext = {{EXT{prod_i[PW-1]}}, prod_i};
        end else begin : g_same
            assign prod_ext = prod_i;
        end
    endgenerate

    always_comb begin
        acc_o = acc_i;
        case (op_i)
            MAC_LOAD: acc_o = prod_ext;
            MAC_ACC:  acc_o = acc_i + prod_ext;   // wraps modulo 2^ACC_W
            default:  acc_o = acc_i;
        endcase
        upd_o = op_updates(op_i);
    end

endmodule

// File: rtl/q23_mac.sv
module q23_mac
    import q23_mac_pkg::*;
#(
    parameter int DW    = 24,
    parameter int ACC_W = 48
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [1:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output logic          vld_o
);
    localparam int PW    = 2 * DW;
    localparam int SL_HI = PW - 2;

    typedef struct packed {
        logic [1:0]              op;
        logic signed [PW-1:0]    prod;
        logic signed [ACC_W-1:0] acc;
        logic [DW-1:0]           res;
        logic                    vld;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic signed [PW-1:0]    prod_w;
    logic signed [ACC_W-1:0] acc_nx;
    logic                    upd_w;
    logic signed [ACC_W-1:0] acc_w;

    // Stage 1: full-precision product
    q23_mult #(.DW(DW)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod_w)
    );

    // Stage 2: accumulator update from registered product and op
    q23_acc_update #(.PW(PW), .ACC_W(ACC_W)) u_upd (
        .op_i   (st_q.op),
        .prod_i (st_q.prod),
        .acc_i  (st_q.acc),
        .acc_o  (acc_nx),
        .upd_o  (upd_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.op   = op_i;
        st_d.prod = prod_w;
        st_d.acc  = acc_nx;
        st_d.vld  = upd_w;
        if (upd_w) begin
            st_d.res = acc_nx[SL_HI -: DW];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign vld_o = st_q.vld;
    assign acc_w = st_q.acc;

endmodule

// File: rtl/q23_mac_chk.sv
module q23_mac_chk
    import q23_mac_pkg::*;
#(
    parameter int DW    = 24,
    parameter int ACC_W = 48
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic [1:0]              op_i,
    input logic [DW-1:0]           a_i,
    input logic [DW-1:0]           b_i,
    input logic [DW-1:0]           res_o,
    input logic                    vld_o,
    input logic signed [ACC_W-1:0] acc_i
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0]    pr_ref;
    logic signed [ACC_W-1:0] ext_ref;
    logic [1:0]              age_q = 2'd0;

    assign pr_ref  = PW'($signed(a_i)) * PW'($signed(b_i));
    assign ext_ref = ACC_W'(pr_ref);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R9
    rst_clr_chk: assert property (@(posedge clk_i)
        rst_i |=> (res_o == '0 && !vld_o && acc_i == '0));

    // R8
    vld_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 2'd2) |-> (vld_o == op_updates($past(op_i, 2))));

    // R3
    load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 2'd2 && $past(op_i, 2) == MAC_LOAD) |-> (acc_i == $past(ext_ref, 2)));

    // R4
    acc_add_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 2'd2 && $past(op_i, 2) == MAC_ACC) |-> (acc_i == $past(acc_i) + $past(ext_ref, 2)));

    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 2'd2 && !op_updates($past(op_i, 2))) |-> ($stable(acc_i) && $stable(res_o) && !vld_o));

    // R2
    slice_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |-> (res_o == acc_i[PW-2 -: DW]));

endmodule

bind q23_mac q23_mac_chk #(.DW(DW), .ACC_W(ACC_W)) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (res_o),
    .vld_o (vld_o),
    .acc_i (acc_w)
);

// File: tb/tb_q23_mac.sv
module tb_q23_mac;
    import q23_mac_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;   // 100 MHz

    // Full-width unit
    logic [1:0]  op = MAC_HOLD;
    logic [23:0] a  = '0;
    logic [23:0] b  = '0;
    logic [23:0] res;
    logic        vld;

    // Small unit for exhaustive sweep
    logic [1:0] s_op = MAC_HOLD;
    logic [5:0] s_a  = '0;
    logic [5:0] s_b  = '0;
    logic [5:0] s_res;
    logic       s_vld;

    q23_mac #(.DW(24), .ACC_W(48)) dut (
        .clk_i(clk), .rst_i(rst), .op_i(op), .a_i(a), .b_i(b), .res_o(res), .vld_o(vld)
    );

    q23_mac #(.DW(6), .ACC_W(12)) dut_s (
        .clk_i(clk), .rst_i(rst), .op_i(s_op), .a_i(s_a), .b_i(s_b), .res_o(s_res), .vld_o(s_vld)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [47:0] m  = '0;
    logic [11:0] sm = '0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Issue one op on the full unit, then check two edges later
    task automatic big_op(input logic [1:0] o, input logic [23:0] x, input logic [23:0] y, input string req);
        longint p;
        p  = longint'($signed(x)) * longint'($signed(y));
        op = o; a = x; b = y;
        @(negedge clk);
        op = MAC_HOLD;
        @(negedge clk);
        if (o == MAC_LOAD)     m = p[47:0];
        else if (o == MAC_ACC) m = m + p[47:0];
        chk(req, 32'(res), 32'(m[46:23]));
        chk({req, " R8 vld"}, 32'(vld), 32'(op_updates(o)));
    endtask

    task automatic sm_op(input logic [1:0] o, input logic [5:0] x, input logic [5:0] y, input string req);
        int p;
        p    = int'($signed(x)) * int'($signed(y));
        s_op = o; s_a = x; s_b = y;
        @(negedge clk);
        s_op = MAC_HOLD;
        @(negedge clk);
        if (o == MAC_LOAD)     sm = p[11:0];
        else if (o == MAC_ACC) sm = sm + p[11:0];
        chk(req, 32'(s_res), 32'(sm[10:5]));
        chk({req, " R8 vld"}, 32'(s_vld), 32'(op_updates(o)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 reset res", 32'(res), 32'h0);
        chk("R9 reset vld", 32'(vld), 32'h0);
        chk("R9 reset small res", 32'(s_res), 32'h0);

        // R3/R2: 0.5 * 0.5 = 0.25
        big_op(MAC_LOAD, 24'h400000, 24'h400000, "R3 load 0.5*0.5");
        chk("R2 slice 0.25", 32'(res), 32'h200000);
        // R4: accumulate another 0.25
        big_op(MAC_ACC, 24'h400000, 24'h400000, "R4 acc to 0.5");
        chk("R4 sum 0.5", 32'(res), 32'h400000);
        // R1: mixed signs -0.5 * 0.5
        big_op(MAC_LOAD, 24'hC00000, 24'h400000, "R1 neg*pos");
        chk("R1 -0.25", 32'(res), 32'hE00000);
        // R5: hold, both encodings
        big_op(MAC_HOLD, 24'h7FFFFF, 24'h7FFFFF, "R5 hold 00");
        big_op(MAC_HOLD2, 24'h123456, 24'h654321, "R5 hold 11");
        chk("R5 unchanged", 32'(res), 32'hE00000);
        // R7: tiny products read zero
        big_op(MAC_LOAD, 24'h000001, 24'h000001, "R7 1lsb*1lsb");
        chk("R7 zero", 32'(res), 32'h0);
        big_op(MAC_LOAD, 24'h000FFF, 24'h000700, "R7 small");
        // R6: -1 * -1 then wrap
        big_op(MAC_LOAD, 24'h800000, 24'h800000, "R6 load -1*-1");
        chk("R6 -1sq slice", 32'(res), 32'h800000);
        big_op(MAC_ACC, 24'h800000, 24'h800000, "R6 wrap 1");
        chk("R6 wrapped", 32'(res), 32'h0);
        big_op(MAC_ACC, 24'h800000, 24'h800000, "R6 wrap 2");

        // R8: back-to-back load then accumulate
        begin
            longint p1, p2;
            p1 = longint'($signed(24'h300000)) * longint'($signed(24'h200000));
            p2 = longint'($signed(24'hD00000)) * longint'($signed(24'h100000));
            op = MAC_LOAD; a = 24'h300000; b = 24'h200000;
            @(negedge clk);
            op = MAC_ACC;  a = 24'hD00000; b = 24'h100000;
            @(negedge clk);
            op = MAC_HOLD;
            m  = p1[47:0];
            chk("R8 pipe first", 32'(res), 32'(m[46:23]));
            chk("R8 pipe first vld", 32'(vld), 32'h1);
            @(negedge clk);
            m  = m + p2[47:0];
            chk("R8 pipe second", 32'(res), 32'(m[46:23]));
            chk("R8 pipe second vld", 32'(vld), 32'h1);
            @(negedge clk);
            chk("R8 vld drops", 32'(vld), 32'h0);
        end

        // R9: reset mid-sum clears accumulator
        big_op(MAC_LOAD, 24'h7FFFFF, 24'h400000, "R9 pre-reset load");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m = '0;
        chk("R9 mid reset res", 32'(res), 32'h0);
        chk("R9 mid reset vld", 32'(vld), 32'h0);
        big_op(MAC_ACC, 24'h200000, 24'h400000, "R9 acc after reset");
        chk("R9 acc from zero", 32'(res), 32'h100000);

        // R1/R2/R7: exhaustive load sweep on 6-bit unit
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                sm_op(MAC_LOAD, 6'(i), 6'(j), "R1 R2 sweep");
            end
        end
        // R4/R6: accumulate chain on 12-bit accumulator, wraps several times
        sm_op(MAC_LOAD, 6'h20, 6'h20, "R6 small load");
        for (int k = 0; k < 64; k++) begin
            sm_op(MAC_ACC, 6'(k), 6'(63 - k), "R4 R6 small chain");
        end
        sm_op(MAC_HOLD2, 6'h1F, 6'h1F, "R5 small hold");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule